// File: doc/BRIEF.md
# Load-and-trap register writer

This unit sits at the write-back end of a load pipe. It receives a loaded memory value, the current contents of the destination register, a variant code and the address of the next instruction. From these it builds the new 64-bit register value, merging the loaded data into the destination in one of five ways. It raises a data-exception trap when the value it writes, after masking or extension, is zero.

The register write always happens, including when the trap fires. A zero load therefore leaves zeros in the portion of the register that was written, and the trap reports the next instruction address. All outputs are registered and appear one cycle after the input strobe. An unused variant code yields neither a write nor a trap.

Top module: `ldtrap_writer`

## Requirements
- R1: After reset, `wr_en` and `trap` are low, and `wr_data` and `trap_pc` are zero.
- R2: Variant code 0 (word) writes the low 32 data bits into bits 31:0 of the register and keeps the old bits 63:32.
- R3: Variant code 1 (high word) writes the low 32 data bits into bits 63:32 and keeps the old bits 31:0.
- R4: Variant code 2 (doubleword) writes all 64 data bits.
- R5: Variant code 3 (logical word) zero-extends the low 32 data bits into a 64-bit value.
- R6: Variant code 4 (31-bit) clears data bit 31 and then zero-extends the low 32 bits. A load of 0x80000000 therefore writes zero and traps.
- R7: `trap` is high exactly when the written portion is zero, meaning the 32-bit field for codes 0 and 1 and the full 64 bits for codes 2, 3 and 4. When it is high, `trap_pc` equals the next instruction address that came with the strobe.
- R8: The write happens even when the trap fires, and the written portion is then zero.
- R9: `wr_en` and `trap` are registered. Each is asserted only in the cycle after a cycle with `in_valid` high, and they are low one cycle after `in_valid` is low.
- R10: Variant codes 5, 6 and 7 give no write and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for one load result |
| variant | input | 3 | Load variant code (0 to 4 valid) |
| mem_data | input | 64 | Loaded data; 32-bit variants use bits 31:0 |
| old_reg | input | 64 | Current destination register contents |
| next_pc | input | 64 | Next instruction address |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 64 | New destination register value |
| trap | output | 1 | Data-exception trap flag |
| trap_pc | output | 64 | Address reported with the trap |

## Verification
The assertions assume that the inputs are known whenever `in_valid` is high and that reset is held for at least one edge before the first strobe. They compare each registered output against a copy of the previous cycle's inputs taken by `$past`. The bench drives inputs only on the falling edge and releases `in_valid` between scenarios, so every assertion window sees a single well-defined input set. The zero and 0x80000000 loads are applied with non-zero old register contents. This shows that the merge keeps the untouched half while the trap still fires.

// File: rtl/ldtrap_pkg.sv
package ldtrap_pkg;
  typedef enum logic [2:0] {
    LV_WORD  = 3'd0,
    LV_HIGH  = 3'd1,
    LV_DWORD = 3'd2,
    LV_LWORD = 3'd3,
    LV_L31   = 3'd4
  } ld_variant_e;

  typedef struct packed {
    logic        we;
    logic        trap;
    logic [63:0] value;
  } merge_res_t;
endpackage

// File: rtl/ldtrap_extend.sv
module ldtrap_extend #(
  parameter int XLEN = 64,
  parameter int HLEN = 32
) (
  input  logic [2:0]      variant,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] ext,
  output logic            wide,
  output logic            known
);
  import ldtrap_pkg::*;
  logic [HLEN-1:0] lo;
  assign lo = data[HLEN-1:0];
  always_comb begin
    ext   = '0;
    wide  = 1'b0;
    known = 1'b1;
    case (variant)
      LV_WORD, LV_HIGH: ext = {{(XLEN-HLEN){1'b0}}, lo};
      LV_DWORD: begin ext = data; wide = 1'b1; end
      LV_LWORD: begin ext = {{(XLEN-HLEN){1'b0}}, lo}; wide = 1'b1; end
      LV_L31: begin
        ext = {{(XLEN-HLEN+1){1'b0}}, lo[HLEN-2:0]};
        wide = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldtrap_merge.sv
module ldtrap_merge #(
  parameter int XLEN = 64,
  parameter int HLEN = 32
) (
  input  logic [2:0]      variant,
  input  logic [XLEN-1:0] ext,
  input  logic            wide,
  input  logic            known,
  input  logic [XLEN-1:0] old_reg,
  output ldtrap_pkg::merge_res_t res
);
  import ldtrap_pkg::*;
  logic zero_lo, zero_all;
  assign zero_lo  = (ext[HLEN-1:0] == '0);
  assign zero_all = (ext == '0);
  always_comb begin
    res.we    = known;
    res.value = old_reg;
    if (wide)
      res.value = ext;
    else if (variant == LV_HIGH)
      res.value = {ext[HLEN-1:0], old_reg[HLEN-1:0]};
    else if (variant == LV_WORD)
      res.value = {old_reg[XLEN-1:HLEN], ext[HLEN-1:0]};
    res.trap = known & (wide ? zero_all : zero_lo);
  end
endmodule

// File: rtl/ldtrap_writer.sv
module ldtrap_writer #(
  parameter int XLEN = 64,
  parameter int HLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      variant,
  input  logic [XLEN-1:0] mem_data,
  input  logic [XLEN-1:0] old_reg,
  input  logic [XLEN-1:0] next_pc,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic            trap,
  output logic [XLEN-1:0] trap_pc
);
  import ldtrap_pkg::*;
  logic [XLEN-1:0] ext;
  logic wide, known;
  merge_res_t res;

  ldtrap_extend #(.XLEN(XLEN), .HLEN(HLEN)) u_ext (
    .variant(variant), .data(mem_data), .ext(ext), .wide(wide), .known(known)
  );
  ldtrap_merge #(.XLEN(XLEN), .HLEN(HLEN)) u_mrg (
    .variant(variant), .ext(ext), .wide(wide), .known(known),
    .old_reg(old_reg), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      trap    <= 1'b0;
      wr_data <= '0;
      trap_pc <= '0;
    end else begin
      wr_en <= in_valid & res.we;
      trap  <= in_valid & res.trap;
      if (in_valid & res.we) wr_data <= res.value;
      if (in_valid & res.trap) trap_pc <= next_pc;
    end
  end
endmodule

// File: rtl/ldtrap_writer_chk.sv
module ldtrap_writer_chk #(
  parameter int XLEN = 64,
  parameter int HLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      variant,
  input logic [XLEN-1:0] mem_data,
  input logic [XLEN-1:0] old_reg,
  input logic [XLEN-1:0] next_pc,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data,
  input logic            trap,
  input logic [XLEN-1:0] trap_pc
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R9
  wen_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !in_valid |=> !wr_en && !trap);
  // R10
  bad_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && in_valid && variant > 3'd4 |=> !wr_en && !trap);
  // R8
  trap_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> wr_en);
  // R7
  trap_pc_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && in_valid && variant <= 3'd4 |=> (trap == 1'b0) || (trap_pc == $past(next_pc)));
  // R2
  word_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && in_valid && variant == 3'd0 |=> wr_data[XLEN-1:HLEN] == $past(old_reg[XLEN-1:HLEN]));
  // R3
  high_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && in_valid && variant == 3'd1 |=> wr_data[HLEN-1:0] == $past(old_reg[HLEN-1:0]));
  // R6
  l31_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && in_valid && variant == 3'd4 |=> wr_data[XLEN-1:HLEN-1] == '0);
endmodule

bind ldtrap_writer ldtrap_writer_chk #(.XLEN(XLEN), .HLEN(HLEN)) u_chk (.*);

// File: tb/ldtrap_writer_test.sv
module ldtrap_writer_test;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [2:0] variant = 0;
  logic [63:0] mem_data = 0, old_reg = 0, next_pc = 0;
  logic wr_en, trap;
  logic [63:0] wr_data, trap_pc;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  ldtrap_writer uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] v, logic [63:0] d, logic [63:0] o, logic [63:0] pc);
    @(negedge clk);
    in_valid = 1; variant = v; mem_data = d; old_reg = o; next_pc = pc;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_out(string req, logic ew, logic [63:0] ed, logic et, logic [63:0] epc);
    chk(req, {63'd0, wr_en}, {63'd0, ew});
    if (ew) chk(req, wr_data, ed);
    chk(req, {63'd0, trap}, {63'd0, et});
    if (et) chk(req, trap_pc, epc);
  endtask

  task automatic t_reset();
    expect_out("R1", 0, 0, 0, 0);
    chk("R1", wr_data, 0);
    chk("R1", trap_pc, 0);
  endtask

  task automatic t_word();
    apply(0, 64'hAAAA_0000_1234_5678, 64'hDEAD_BEEF_CAFE_F00D, 64'h100);
    expect_out("R2", 1, 64'hDEAD_BEEF_1234_5678, 0, 0);
    apply(0, 64'hFFFF_FFFF_0000_0000, 64'h1111_2222_3333_4444, 64'h104);
    expect_out("R8", 1, 64'h1111_2222_0000_0000, 1, 64'h104);
  endtask

  task automatic t_high();
    apply(1, 64'h0000_0000_EDCB_A988, 64'h0123_4567_89AB_CDEF, 64'h200);
    expect_out("R3", 1, 64'hEDCB_A988_89AB_CDEF, 0, 0);
    apply(1, 64'h5555_5555_0000_0000, 64'h0123_4567_89AB_CDEF, 64'h208);
    expect_out("R7", 1, 64'h0000_0000_89AB_CDEF, 1, 64'h208);
  endtask

  task automatic t_dword();
    apply(2, 64'h8000_0000_0000_0000, 64'h7, 64'h300);
    expect_out("R4", 1, 64'h8000_0000_0000_0000, 0, 0);
    apply(2, 64'h0, 64'h7, 64'h310);
    expect_out("R7", 1, 64'h0, 1, 64'h310);
  endtask

  task automatic t_lword();
    apply(3, 64'h9999_9999_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h400);
    expect_out("R5", 1, 64'h0000_0000_8000_0000, 0, 0);
    apply(3, 64'h9999_9999_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h404);
    expect_out("R7", 1, 64'h0, 1, 64'h404);
  endtask

  task automatic t_l31();
    apply(4, 64'h0000_0000_EDCB_A988, 64'hFFFF_FFFF_FFFF_FFFF, 64'h500);
    expect_out("R6", 1, 64'h0000_0000_6DCB_A988, 0, 0);
    apply(4, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h508);
    expect_out("R6", 1, 64'h0, 1, 64'h508);
  endtask

  task automatic t_bad();
    for (int v = 5; v < 8; v++) begin
      apply(v[2:0], 64'h0, 64'h1, 64'h600);
      expect_out("R10", 0, 0, 0, 0);
    end
  endtask

  task automatic t_idle();
    apply(2, 64'h0, 64'h0, 64'h700);
    @(negedge clk);
    expect_out("R9", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_word();
    t_high();
    t_dword();
    t_lword();
    t_l31();
    t_bad();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule